// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block gathers level-sensitive interrupt lines and steers each one to any subset of up to four processors. Software programs it through a small register bus. A source is switched on or off with one write of its number to a "set" or a "clear" strobe address, so no read-modify-write of bit vectors is needed. Each processor also has a private mask that is updated the same way, through the same addresses. Each source has a routing register that selects the processors allowed to receive it.

Every processor has an interrupt output. It also has an acknowledge register that returns the lowest-numbered source currently pending for it, or a fixed "nothing pending" code. Sources 0 and 1 are per-processor summary lines from the doorbell logic. They come in on a separate per-CPU input, skip the global enable and the routing, and depend only on that processor's mask. Sources are level sensitive: a source stays pending while its line is high, and reading the acknowledge register changes no state. Bus accesses carry a CPU number that selects which processor's mask or acknowledge register is used.

Top module: `mcic_core`

## Requirements
- R1: After reset every source is disabled, every source is masked on every CPU, and every routing field is 0. As a result every irq_o bit is low and every acknowledge read returns 1023.
- R2: A read of address 0x000 returns the number of implemented sources in bits [11:2], with all other bits 0. With 32 sources the value is 0x80.
- R3: Writing a source number to 0x030 enables that source globally, and writing it to 0x034 disables it. A written value that is not below the source count changes no enable, and no part of it wraps onto a valid source.
- R4: Writing a source number to 0x048 masks that source, and writing it to 0x04C unmasks it. Both act only for the CPU given on bus_cpu; the masks of the other CPUs are left unchanged.
- R5: Source n has a routing register at 0x100 + 4*n. Bits [3:0] hold the routing, with bit c selecting CPU c. Writes keep only those bits, and reads return them with the upper bits 0.
- R6: A source numbered 2 or above is pending for CPU c exactly when its glb_lvl line is high, it is enabled, its routing bit c is 1 and CPU c has it unmasked. Several routing bits deliver the source to several CPUs at once.
- R7: Sources 0 and 1 of CPU c come from cpu_lvl[2*c] and cpu_lvl[2*c+1]. They are pending when that line is high and CPU c has the source unmasked. Enable and routing have no effect on them.
- R8: Reading 0x044 returns, in bits [9:0], the lowest-numbered source pending for the CPU on bus_cpu, or 1023 when none is pending. The upper bits are 0. Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.
- R9: irq_o[c] is high exactly when at least one source is pending for CPU c.
- R10: An acknowledge read has no side effect. A pending source stays pending, and keeps its place in the acknowledge order, until its line goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu | input | 2 | CPU selected for per-CPU registers |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| glb_lvl | input | 30 | Level lines of sources 31..2 |
| cpu_lvl | input | 8 | Per-CPU lines of sources 0 and 1 |
| irq_o | output | 4 | Interrupt output per CPU |

## Verification
On every cycle, assertions check several properties. A set-enable or set-mask strobe must take effect on the next edge, and a mask strobe must leave the other CPUs' masks alone. An out-of-range source number must leave the enables untouched. A raised irq_o must point at a pending source that has no lower-numbered pending peer. An unmasked per-CPU summary line must always raise its CPU's output. Other behaviour can only be shown by the bench's directed scenarios, because it depends on the programmed values: the reset contents, the source-count field, routing readback and multi-hot delivery, acknowledge order as lines drop one by one, and acknowledge reads that leave state unchanged.

// File: rtl/mcic_pkg.sv
package mcic_pkg;
    localparam int DEF_NUM_SRC = 32;
    localparam int DEF_NUM_CPU = 4;
    localparam int LOCAL_SRC   = 2;
    localparam int ACK_NONE    = 1023;

    localparam int OFF_CTRL     = 'h000;
    localparam int OFF_EN_SET   = 'h030;
    localparam int OFF_EN_CLR   = 'h034;
    localparam int OFF_ACK      = 'h044;
    localparam int OFF_MSK_SET  = 'h048;
    localparam int OFF_MSK_CLR  = 'h04C;
    localparam int OFF_ROUTE    = 'h100;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_CTRL,
        RD_ACK,
        RD_ROUTE
    } rd_sel_e;
endpackage

// File: rtl/mcic_decode.sv
module mcic_decode
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_op_e            op,
    output rd_sel_e           rsel,
    output logic [SRC_W-1:0]  widx,
    output logic [SRC_W-1:0]  ridx
);
    localparam logic [ADDR_W-1:0] RT_LO   = ADDR_W'(OFF_ROUTE);
    localparam logic [ADDR_W-1:0] RT_SPAN = ADDR_W'(4 * NUM_SRC);

    logic [ADDR_W-1:0] rt_off;
    logic              rt_hit;
    logic              idx_ok;

    always_comb begin
        rt_off = addr - RT_LO;
        rt_hit = (addr >= RT_LO) && (rt_off < RT_SPAN) && (rt_off[1:0] == 2'b00);
        ridx   = rt_off[SRC_W+1:2];
        idx_ok = wdata < DATA_W'(NUM_SRC);
        widx   = wdata[SRC_W-1:0];

        op = OP_NONE;
        if (wr) begin
            if (rt_hit)                                     op = OP_ROUTE;
            else if (idx_ok && addr == ADDR_W'(OFF_EN_SET))  op = OP_EN_SET;
            else if (idx_ok && addr == ADDR_W'(OFF_EN_CLR))  op = OP_EN_CLR;
            else if (idx_ok && addr == ADDR_W'(OFF_MSK_SET)) op = OP_MSK_SET;
            else if (idx_ok && addr == ADDR_W'(OFF_MSK_CLR)) op = OP_MSK_CLR;
        end

        rsel = RD_NONE;
        if (rd) begin
            if (rt_hit)                                 rsel = RD_ROUTE;
            else if (addr == ADDR_W'(OFF_CTRL))         rsel = RD_CTRL;
            else if (addr == ADDR_W'(OFF_ACK))          rsel = RD_ACK;
        end
    end
endmodule

// File: rtl/mcic_state.sv
module mcic_state
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_CPU = DEF_NUM_CPU,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  wr_op_e                                op,
    input  logic [SRC_W-1:0]                      widx,
    input  logic [SRC_W-1:0]                      ridx,
    input  logic [CPU_W-1:0]                      cpu,
    input  logic [NUM_CPU-1:0]                    route_wdata,
    output logic [NUM_SRC-1:LOCAL_SRC]            en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]       mask_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]       route_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            mask_q  <= '1;
            route_q <= '0;
        end else begin
            case (op)
                OP_EN_SET:  if (int'(widx) >= LOCAL_SRC) en_q[widx] <= 1'b1;
                OP_EN_CLR:  if (int'(widx) >= LOCAL_SRC) en_q[widx] <= 1'b0;
                OP_MSK_SET: mask_q[cpu][widx] <= 1'b1;
                OP_MSK_CLR: mask_q[cpu][widx] <= 1'b0;
                OP_ROUTE:   route_q[ridx] <= route_wdata;
                default: ;
            endcase
        end
    end

    assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EN_SET && int'(widx) >= LOCAL_SRC) |=> en_q[$past(widx)]);

    assert_en_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_EN_CLR && int'(widx) >= LOCAL_SRC) |=> !en_q[$past(widx)]);

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MSK_SET) |=> mask_q[$past(cpu)][$past(widx)]);

    assert_mask_clr_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MSK_CLR) |=> !mask_q[$past(cpu)][$past(widx)]);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_mask_iso
        assert_mask_isolated_R4: assert property (@(posedge clk) disable iff (rst)
            ((op == OP_MSK_SET || op == OP_MSK_CLR) && int'(cpu) != c)
            |=> $stable(mask_q[c]));
    end
endmodule

// File: rtl/mcic_pend.sv
module mcic_pend
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_CPU = DEF_NUM_CPU,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_SRC-1:LOCAL_SRC]            glb_lvl,
    input  logic [NUM_CPU*LOCAL_SRC-1:0]          cpu_lvl,
    input  logic [NUM_SRC-1:LOCAL_SRC]            en_q,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]       mask_q,
    input  logic [NUM_SRC-1:LOCAL_SRC][NUM_CPU-1:0] route,
    output logic [NUM_CPU-1:0]                    irq,
    output logic [NUM_CPU-1:0][SRC_W-1:0]         ack_idx
);
    function automatic logic [SRC_W-1:0] first_set(input logic [NUM_SRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

    logic [NUM_CPU-1:0][NUM_SRC-1:0] pend;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            if (n < LOCAL_SRC) begin : g_local
                assign pend[c][n] = cpu_lvl[c*LOCAL_SRC+n] & ~mask_q[c][n];
            end else begin : g_global
                assign pend[c][n] = glb_lvl[n] & en_q[n] & route[n][c] & ~mask_q[c][n];
            end
        end

        assign irq[c]     = |pend[c];
        assign ack_idx[c] = first_set(pend[c]);

        assert_irq_points_pending_R9: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> pend[c][ack_idx[c]]);

        assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> ((pend[c] & ~({NUM_SRC{1'b1}} << ack_idx[c])) == '0));

        for (genvar n = 0; n < LOCAL_SRC; n++) begin : g_lchk
            assert_local_bypass_R7: assert property (@(posedge clk) disable iff (rst)
                (cpu_lvl[c*LOCAL_SRC+n] && !mask_q[c][n]) |-> irq[c]);
        end
    end
endmodule

// File: rtl/mcic_core.sv
module mcic_core
    import mcic_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int NUM_CPU = DEF_NUM_CPU,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [CPU_W-1:0]             bus_cpu,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic [NUM_SRC-1:LOCAL_SRC]   glb_lvl,
    input  logic [NUM_CPU*LOCAL_SRC-1:0] cpu_lvl,
    output logic [NUM_CPU-1:0]           irq_o
);
    wr_op_e                           op;
    rd_sel_e                          rsel;
    logic [SRC_W-1:0]                 widx;
    logic [SRC_W-1:0]                 ridx;
    logic [NUM_SRC-1:LOCAL_SRC]       en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]  route_q;
    logic [NUM_CPU-1:0][SRC_W-1:0]    ack_idx;

    mcic_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
        .op(op), .rsel(rsel), .widx(widx), .ridx(ridx)
    );

    mcic_state #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_state (
        .clk(clk), .rst(rst), .op(op), .widx(widx), .ridx(ridx), .cpu(bus_cpu),
        .route_wdata(bus_wdata[NUM_CPU-1:0]),
        .en_q(en_q), .mask_q(mask_q), .route_q(route_q)
    );

    mcic_pend #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_pend (
        .clk(clk), .rst(rst), .glb_lvl(glb_lvl), .cpu_lvl(cpu_lvl),
        .en_q(en_q), .mask_q(mask_q), .route(route_q[NUM_SRC-1:LOCAL_SRC]),
        .irq(irq_o), .ack_idx(ack_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (rsel)
                RD_CTRL:  bus_rdata <= DATA_W'(NUM_SRC) << 2;
                RD_ACK:   bus_rdata <= irq_o[bus_cpu] ? DATA_W'(ack_idx[bus_cpu])
                                                      : DATA_W'(ACK_NONE);
                RD_ROUTE: bus_rdata <= DATA_W'(route_q[ridx]);
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assert_ack_none_R8: assert property (@(posedge clk) disable iff (rst)
        (rsel == RD_ACK && !irq_o[bus_cpu]) |=> (bus_rdata == DATA_W'(ACK_NONE)));

    assert_bad_index_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == ADDR_W'(OFF_EN_SET) || bus_addr == ADDR_W'(OFF_EN_CLR))
         && bus_wdata >= DATA_W'(NUM_SRC)) |=> $stable(en_q));
endmodule

// File: tb/tb_mcic_core.sv
module tb_mcic_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:2] glb_lvl = '0;
    logic [7:0]  cpu_lvl = '0;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_CTRL = 12'h000, A_ENS = 12'h030, A_ENC = 12'h034,
                            A_ACK = 12'h044, A_MS = 12'h048, A_MC = 12'h04C;

    always #2 clk = ~clk;

    mcic_core dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .glb_lvl(glb_lvl), .cpu_lvl(cpu_lvl), .irq_o(irq_o)
    );

    function automatic logic [11:0] rt(input int n);
        return 12'(12'h100 + 4 * n);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = c;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] c, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_cpu = c;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_irq(input logic [3:0] exp, input string req);
        @(negedge clk);
        check(irq_o == exp, req, 32'(irq_o), 32'(exp));
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [1:0] c,
                          input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, c, d);
        check(d == exp, req, d, exp);
    endtask

    task automatic t_reset;
        chk_irq(4'b0000, "R1 irq after reset");
        for (int c = 0; c < 4; c++) chk_rd(A_ACK, 2'(c), 32'd1023, "R1 ack after reset");
        chk_rd(rt(5), 2'd0, 32'h0, "R1 routing after reset");
        chk_rd(A_CTRL, 2'd0, 32'h80, "R2 source count field");
    endtask

    task automatic t_enable;
        glb_lvl[5] = 1'b1;
        wr(rt(5), 32'h2, 2'd0);
        wr(A_MC, 32'd5, 2'd1);
        chk_irq(4'b0000, "R3 not yet enabled");
        wr(A_ENS, 32'd5, 2'd0);
        chk_irq(4'b0010, "R6 enabled routed unmasked");
        chk_rd(A_ACK, 2'd1, 32'd5, "R8 ack source 5");
        wr(A_ENC, 32'd5, 2'd0);
        chk_irq(4'b0000, "R3 clear enable");
        wr(A_ENS, 32'd37, 2'd0);
        chk_irq(4'b0000, "R3 out-of-range index ignored");
        wr(A_ENS, 32'd5, 2'd0);
        chk_irq(4'b0010, "R3 re-enable");
    endtask

    task automatic t_mask_route;
        wr(rt(5), 32'hFFFF_FFFF, 2'd0);
        chk_rd(rt(5), 2'd0, 32'hF, "R5 routing readback");
        wr(A_MC, 32'd5, 2'd0);
        chk_irq(4'b0011, "R6 multi-hot delivery");
        wr(A_MS, 32'd5, 2'd1);
        chk_irq(4'b0001, "R4 mask only cpu1");
        chk_rd(A_ACK, 2'd1, 32'd1023, "R4 masked cpu ack none");
        wr(rt(5), 32'h4, 2'd0);
        chk_irq(4'b0000, "R5 reroute to masked cpu2");
    endtask

    task automatic t_priority;
        glb_lvl[5] = 1'b0;
        wr(rt(7), 32'h4, 2'd0);
        wr(rt(20), 32'h4, 2'd0);
        wr(A_ENS, 32'd7, 2'd0);
        wr(A_ENS, 32'd20, 2'd0);
        wr(A_MC, 32'd5, 2'd2);
        wr(A_MC, 32'd7, 2'd2);
        wr(A_MC, 32'd20, 2'd2);
        glb_lvl[7] = 1'b1; glb_lvl[20] = 1'b1;
        chk_irq(4'b0100, "R9 cpu2 output");
        chk_rd(A_ACK, 2'd2, 32'd7, "R8 lowest of 7 and 20");
        chk_rd(A_ACK, 2'd2, 32'd7, "R10 ack read has no side effect");
        glb_lvl[7] = 1'b0;
        chk_rd(A_ACK, 2'd2, 32'd20, "R10 next after line drops");
        glb_lvl[5] = 1'b1;
        chk_rd(A_ACK, 2'd2, 32'd5, "R8 lower source wins");
        glb_lvl = '0;
        chk_irq(4'b0000, "R10 cleared by deassert");
    endtask

    task automatic t_local;
        cpu_lvl[6] = 1'b1;
        cpu_lvl[4] = 1'b1;
        chk_irq(4'b0000, "R7 local source masked");
        wr(A_MC, 32'd0, 2'd3);
        chk_irq(4'b1000, "R7 local bypasses enable and routing");
        chk_rd(A_ACK, 2'd3, 32'd0, "R7 ack local 0");
        cpu_lvl[7] = 1'b1;
        wr(A_MC, 32'd1, 2'd3);
        cpu_lvl[6] = 1'b0;
        chk_rd(A_ACK, 2'd3, 32'd1, "R7 ack local 1");
        chk_rd(A_ACK, 2'd2, 32'd1023, "R7 other cpu local still masked");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_mask_route();
        t_priority();
        t_local();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule